// File: doc/BRIEF.md
# Three-Level PWM Gate Sequencer

This block sits between the input comparators of a synchronous buck power stage and its two gate drivers. It receives a three-level PWM command as two synchronous flags, `pwm_hi` and `pwm_lo`. Exactly one flag set means high or low. Neither or both set means mid-level. From this command it produces the high-side and low-side gate enables. A level filter rejects short glitches and stretches short high pulses. It also turns a mid-level that persists into a shutdown command. A sequencer then makes sure the two gates are never on together. It does this with a programmable dead time before the high side turns on. Before the low side turns on, it waits for the high gate to be reported discharged and then runs a fixed delay.

The low side can be blocked on its own by `ls_off_n`. A supply-monitor `enable` removes both gates. All times are parameters counted in clock cycles.

The sequencer states are IDLE (both off), HS_DEAD (dead time before the high side), HS_ON, HS_PROP (high side held through the turn-off propagation delay), DRAIN (high side off, waiting for the discharged flag), LS_DLY (delay after discharge) and LS_ON. Its transitions are as follows:
- enable low: any state goes to IDLE.
- Accepted high: IDLE, DRAIN, LS_DLY and LS_ON go to HS_DEAD. HS_PROP goes back to HS_ON.
- HS_DEAD goes to HS_ON when its DEAD_CYC count completes.
- HS_ON goes to HS_PROP when the accepted level leaves high.
- HS_PROP goes to DRAIN after PROP_CYC cycles.
- Accepted low: IDLE and HS_DEAD go to DRAIN.
- DRAIN goes to LS_DLY when `hs_discharged` is seen.
- LS_DLY goes to LS_ON after LS_DLY_CYC cycles.
- Accepted mid-level: HS_DEAD, DRAIN, LS_DLY and LS_ON go to IDLE.

Top module: `pwm_gate_seq`

## Requirements
- R1: The raw level is high when only `pwm_hi` is set and low when only `pwm_lo` is set. When neither or both are set, it is mid-level.
- R2: A new high or low raw level is accepted only after it has been present for DETECT_CYC consecutive cycles. A shorter pulse is ignored.
- R3: Once accepted, a high level stays accepted for at least MIN_ON_CYC cycles, even when the raw input leaves sooner. The short pulse is stretched.
- R4: A mid-level is accepted after HOLD_LO_CYC consecutive cycles when it follows low, and after HOLD_HI_CYC cycles when it follows high. The sequencer then returns to IDLE with both gates off.
- R5: When high is accepted, the low gate goes off. The high gate turns on only after DEAD_CYC cycles in HS_DEAD with both gates off.
- R6: When the accepted level leaves high, the high gate stays on for PROP_CYC further cycles before it turns off.
- R7: The low gate turns on only after the high gate is off, `hs_discharged` has been seen in DRAIN, and LS_DLY_CYC more cycles have passed with low still accepted.
- R8: While `ls_off_n` is low, `gate_ls` is low in that same cycle. `ls_off_n` has no effect on `gate_hs`.
- R9: While `enable` is low, both gates are low in that same cycle. The sequencer restarts from IDLE.
- R10: `gate_hs` and `gate_ls` are never high in the same cycle.
- R11: During and after reset, both gates are low and the accepted level is mid-level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Supply monitor good; low forces both gates off |
| pwm_hi | input | 1 | PWM input above the high threshold |
| pwm_lo | input | 1 | PWM input below the low threshold |
| ls_off_n | input | 1 | Active-low low-side block |
| hs_discharged | input | 1 | High-side gate voltage is below its off threshold |
| gate_hs | output | 1 | High-side gate enable |
| gate_ls | output | 1 | Low-side gate enable |

## Verification
A raw level first sampled at clock edge e becomes the accepted command after edge e+DETECT_CYC-1, or after the matching hold-off for mid-level. The sequencer state moves at the following edge. The high gate rises DEAD_CYC edges after that. `enable` and `ls_off_n` act on the outputs combinationally, within the same cycle. The bench drives inputs on the falling edge and compares both gates one nanosecond later against a cycle model built from these rules. Each rising edge advances that model exactly once, so every expected value lines up with the cycle in which the register chain delivers it.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

    typedef enum logic [1:0] {
        LVL_MID  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } level_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HS_DEAD = 3'd1,
        ST_HS_ON   = 3'd2,
        ST_HS_PROP = 3'd3,
        ST_DRAIN   = 3'd4,
        ST_LS_DLY  = 3'd5,
        ST_LS_ON   = 3'd6
    } seq_state_t;

    // Exactly one flag selects a rail level; anything else reads as mid-level.
    function automatic level_t decode_level(input logic hi, input logic lo);
        if (hi && !lo)      return LVL_HIGH;
        else if (lo && !hi) return LVL_LOW;
        else                return LVL_MID;
    endfunction

endpackage

// File: rtl/pwm_level_filter.sv
module pwm_level_filter
    import pwm_gate_pkg::*;
#(
    parameter int DETECT_CYC  = 2,
    parameter int MIN_ON_CYC  = 3,
    parameter int HOLD_LO_CYC = 4,
    parameter int HOLD_HI_CYC = 5
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pwm_hi,
    input  logic   pwm_lo,
    output level_t cmd
);
    localparam int MAX_A    = (DETECT_CYC > HOLD_LO_CYC) ? DETECT_CYC : HOLD_LO_CYC;
    localparam int MAX_NEED = (MAX_A > HOLD_HI_CYC) ? MAX_A : HOLD_HI_CYC;
    localparam int RUN_W    = $clog2(MAX_NEED + 1);
    localparam int AGE_W    = $clog2(MIN_ON_CYC + 1);

    localparam logic [RUN_W-1:0] NEED_DET = RUN_W'(DETECT_CYC);
    localparam logic [RUN_W-1:0] NEED_LO  = RUN_W'(HOLD_LO_CYC);
    localparam logic [RUN_W-1:0] NEED_HI  = RUN_W'(HOLD_HI_CYC);
    localparam logic [RUN_W-1:0] RUN_MAX  = '1;
    localparam logic [AGE_W-1:0] AGE_MIN  = AGE_W'(MIN_ON_CYC);
    localparam logic [AGE_W-1:0] AGE_MAX  = '1;

    level_t           raw, cand;
    logic [RUN_W-1:0] run, run_nxt, need;
    logic [AGE_W-1:0] age;
    logic             hold_blk, take;

    always_comb begin
        raw      = decode_level(pwm_hi, pwm_lo);
        run_nxt  = (raw == cand) ? ((run == RUN_MAX) ? run : run + 1'b1) : RUN_W'(1);
        if (raw == LVL_MID) need = (cmd == LVL_HIGH) ? NEED_HI : NEED_LO;
        else                need = NEED_DET;
        hold_blk = (cmd == LVL_HIGH) && (age < AGE_MIN);
        take     = (raw != cmd) && (run_nxt >= need) && !hold_blk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand <= LVL_MID;
            run  <= '0;
            cmd  <= LVL_MID;
            age  <= '0;
        end else begin
            cand <= raw;
            run  <= run_nxt;
            if (take) begin
                cmd <= raw;
                age <= AGE_W'(1);
            end else if (age != AGE_MAX) begin
                age <= age + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_gate_fsm.sv
module pwm_gate_fsm
    import pwm_gate_pkg::*;
#(
    parameter int DEAD_CYC   = 2,
    parameter int PROP_CYC   = 3,
    parameter int LS_DLY_CYC = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   ls_off_n,
    input  logic   hs_discharged,
    input  level_t cmd,
    output logic   gate_hs,
    output logic   gate_ls
);
    localparam int MAX_A = (DEAD_CYC > PROP_CYC) ? DEAD_CYC : PROP_CYC;
    localparam int MAX_C = (MAX_A > LS_DLY_CYC) ? MAX_A : LS_DLY_CYC;
    localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    localparam logic [CNT_W-1:0] LAST_DEAD = CNT_W'(DEAD_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_PROP = CNT_W'(PROP_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_LSD  = CNT_W'(LS_DLY_CYC - 1);

    seq_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = '0;
        if (!enable) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd == LVL_HIGH)     state_nxt = ST_HS_DEAD;
                    else if (cmd == LVL_LOW) state_nxt = ST_DRAIN;
                end
                ST_HS_DEAD: begin
                    if (cmd == LVL_LOW)      state_nxt = ST_DRAIN;
                    else if (cmd == LVL_MID) state_nxt = ST_IDLE;
                    else if (cnt == LAST_DEAD) state_nxt = ST_HS_ON;
                    else cnt_nxt = cnt + 1'b1;
                end
                ST_HS_ON: begin
                    if (cmd != LVL_HIGH) state_nxt = ST_HS_PROP;
                end
                ST_HS_PROP: begin
                    if (cmd == LVL_HIGH)       state_nxt = ST_HS_ON;
                    else if (cnt == LAST_PROP) state_nxt = ST_DRAIN;
                    else cnt_nxt = cnt + 1'b1;
                end
                ST_DRAIN: begin
                    if (cmd == LVL_HIGH)     state_nxt = ST_HS_DEAD;
                    else if (cmd == LVL_MID) state_nxt = ST_IDLE;
                    else if (hs_discharged)  state_nxt = ST_LS_DLY;
                end
                ST_LS_DLY: begin
                    if (cmd == LVL_HIGH)      state_nxt = ST_HS_DEAD;
                    else if (cmd == LVL_MID)  state_nxt = ST_IDLE;
                    else if (cnt == LAST_LSD) state_nxt = ST_LS_ON;
                    else cnt_nxt = cnt + 1'b1;
                end
                ST_LS_ON: begin
                    if (cmd == LVL_HIGH)     state_nxt = ST_HS_DEAD;
                    else if (cmd == LVL_MID) state_nxt = ST_IDLE;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        gate_hs = enable && ((state == ST_HS_ON) || (state == ST_HS_PROP));
        gate_ls = enable && ls_off_n && (state == ST_LS_ON);
    end

endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq
    import pwm_gate_pkg::*;
#(
    parameter int DETECT_CYC  = 2,
    parameter int MIN_ON_CYC  = 3,
    parameter int HOLD_LO_CYC = 4,
    parameter int HOLD_HI_CYC = 5,
    parameter int DEAD_CYC    = 2,
    parameter int PROP_CYC    = 3,
    parameter int LS_DLY_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pwm_hi,
    input  logic pwm_lo,
    input  logic ls_off_n,
    input  logic hs_discharged,
    output logic gate_hs,
    output logic gate_ls
);
    level_t cmd;

    pwm_level_filter #(
        .DETECT_CYC (DETECT_CYC),
        .MIN_ON_CYC (MIN_ON_CYC),
        .HOLD_LO_CYC(HOLD_LO_CYC),
        .HOLD_HI_CYC(HOLD_HI_CYC)
    ) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pwm_hi(pwm_hi),
        .pwm_lo(pwm_lo),
        .cmd   (cmd)
    );

    pwm_gate_fsm #(
        .DEAD_CYC  (DEAD_CYC),
        .PROP_CYC  (PROP_CYC),
        .LS_DLY_CYC(LS_DLY_CYC)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .ls_off_n     (ls_off_n),
        .hs_discharged(hs_discharged),
        .cmd          (cmd),
        .gate_hs      (gate_hs),
        .gate_ls      (gate_ls)
    );

endmodule

// File: rtl/pwm_gate_seq_chk.sv
module pwm_gate_seq_chk #(
    parameter int DEAD_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic hs_discharged,
    input logic gate_hs,
    input logic gate_ls
);
    localparam logic [7:0] DEAD_L = 8'(DEAD_CYC);

    logic [7:0] off_run;
    logic       drained;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run <= '0;
            drained <= 1'b0;
        end else begin
            if (gate_hs || gate_ls)   off_run <= '0;
            else if (off_run != 8'hFF) off_run <= off_run + 1'b1;
            if (gate_hs)                          drained <= 1'b0;
            else if (hs_discharged)               drained <= 1'b1;
        end
    end

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hs && gate_ls));

    // R5
    dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hs) |-> (off_run >= DEAD_L));

    // R7
    ls_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ls) |-> drained);

    // R9
    en_hs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !gate_hs);

    // R9
    en_ls_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !gate_ls);

endmodule

bind pwm_gate_seq pwm_gate_seq_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .hs_discharged(hs_discharged),
    .gate_hs      (gate_hs),
    .gate_ls      (gate_ls)
);

// File: tb/pwm_gate_seq_tb.sv
module pwm_gate_seq_tb_top;
    localparam int DET = 2, MINON = 3, HLO = 4, HHI = 5, DEAD = 2, PROP = 3, LSD = 2;
    // model encodings
    localparam int MID = 0, LOW = 1, HIGH = 2;
    localparam int S_IDLE = 0, S_DEAD = 1, S_HON = 2, S_PROP = 3, S_DRAIN = 4, S_LSD = 5, S_LON = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1, pwm_hi = 1'b0, pwm_lo = 1'b0, ls_off_n = 1'b1, hs_discharged = 1'b1;
    logic gate_hs, gate_ls;

    int checks = 0, failures = 0;
    int m_cand = MID, m_run = 0, m_acc = MID, m_age = 0, m_st = S_IDLE, m_cnt = 0;

    always #5 clk = ~clk;

    pwm_gate_seq #(
        .DETECT_CYC(DET), .MIN_ON_CYC(MINON), .HOLD_LO_CYC(HLO), .HOLD_HI_CYC(HHI),
        .DEAD_CYC(DEAD), .PROP_CYC(PROP), .LS_DLY_CYC(LSD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .ls_off_n(ls_off_n), .hs_discharged(hs_discharged),
        .gate_hs(gate_hs), .gate_ls(gate_ls)
    );

    function automatic int lvl(input logic hi, input logic lo);
        if (hi && !lo) return HIGH;
        if (lo && !hi) return LOW;
        return MID;
    endfunction

    function automatic logic exp_hs();
        return enable && (m_st == S_HON || m_st == S_PROP);
    endfunction

    function automatic logic exp_ls();
        return enable && ls_off_n && (m_st == S_LON);
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        int r, run_n, need, st_n, cnt_n;
        logic take;
        r     = lvl(pwm_hi, pwm_lo);
        run_n = (r == m_cand) ? m_run + 1 : 1;
        need  = (r == MID) ? ((m_acc == HIGH) ? HHI : HLO) : DET;
        take  = (r != m_acc) && (run_n >= need) && !((m_acc == HIGH) && (m_age < MINON));
        st_n = m_st;
        cnt_n = 0;
        if (!enable) st_n = S_IDLE;
        else case (m_st)
            S_IDLE:  if (m_acc == HIGH) st_n = S_DEAD; else if (m_acc == LOW) st_n = S_DRAIN;
            S_DEAD:  if (m_acc == LOW) st_n = S_DRAIN; else if (m_acc == MID) st_n = S_IDLE;
                     else if (m_cnt == DEAD - 1) st_n = S_HON; else cnt_n = m_cnt + 1;
            S_HON:   if (m_acc != HIGH) st_n = S_PROP;
            S_PROP:  if (m_acc == HIGH) st_n = S_HON;
                     else if (m_cnt == PROP - 1) st_n = S_DRAIN; else cnt_n = m_cnt + 1;
            S_DRAIN: if (m_acc == HIGH) st_n = S_DEAD; else if (m_acc == MID) st_n = S_IDLE;
                     else if (hs_discharged) st_n = S_LSD;
            S_LSD:   if (m_acc == HIGH) st_n = S_DEAD; else if (m_acc == MID) st_n = S_IDLE;
                     else if (m_cnt == LSD - 1) st_n = S_LON; else cnt_n = m_cnt + 1;
            default: if (m_acc == HIGH) st_n = S_DEAD; else if (m_acc == MID) st_n = S_IDLE;
        endcase
        m_cand = r;
        m_run  = run_n;
        if (take) begin m_acc = r; m_age = 1; end else m_age = m_age + 1;
        m_st  = st_n;
        m_cnt = cnt_n;
    endtask

    // One cycle: drive on the falling edge, compare, then advance the model for the next rising edge.
    task automatic cyc(input logic hi, input logic lo, input logic en, input logic offn,
                       input logic dis, input string req);
        @(negedge clk);
        pwm_hi = hi; pwm_lo = lo; enable = en; ls_off_n = offn; hs_discharged = dis;
        #1;
        check(req, "gate_hs", gate_hs, exp_hs());
        check(req, "gate_ls", gate_ls, exp_ls());
        check("R10", "overlap", gate_hs && gate_ls, 1'b0);
        if (rst_n) model_update();
    endtask

    task automatic hold(input int n, input logic hi, input logic lo, input logic en,
                        input logic offn, input logic dis, input string req);
        for (int i = 0; i < n; i++) cyc(hi, lo, en, offn, dis, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R11: gates stay low under reset even with a high command
        hold(4, 1, 0, 1, 1, 1, "R11");
        @(negedge clk); rst_n = 1'b1;
        hold(4, 0, 0, 1, 1, 1, "R11");
        // R2: one-cycle glitches on either rail are ignored
        hold(1, 1, 0, 1, 1, 1, "R2");
        hold(6, 0, 0, 1, 1, 1, "R2");
        hold(1, 0, 1, 1, 1, 1, "R2");
        hold(6, 0, 0, 1, 1, 1, "R2");
        // R7: low side after drain and delay
        hold(12, 0, 1, 1, 1, 1, "R7");
        // R5: dead time on rising command
        hold(12, 1, 0, 1, 1, 1, "R5");
        // R6: propagation hold on falling command, then R7 again
        hold(12, 0, 1, 1, 1, 1, "R6");
        // R3: minimum-width high pulse gets stretched
        hold(2, 1, 0, 1, 1, 1, "R3");
        hold(14, 0, 1, 1, 1, 1, "R3");
        // R4: mid-level hold-off from low, then from high
        hold(10, 0, 0, 1, 1, 1, "R4");
        hold(12, 1, 0, 1, 1, 1, "R4");
        hold(12, 0, 0, 1, 1, 1, "R4");
        // R1: both flags set reads as mid-level
        hold(12, 0, 1, 1, 1, 1, "R1");
        hold(10, 1, 1, 1, 1, 1, "R1");
        // R8: low-side block, then high side unaffected by the block
        hold(10, 0, 1, 1, 0, 1, "R8");
        hold(6, 0, 1, 1, 1, 1, "R8");
        hold(12, 1, 0, 1, 0, 1, "R8");
        // R7: discharge flag withheld keeps low side off
        hold(8, 0, 1, 1, 1, 0, "R7");
        hold(6, 0, 1, 1, 1, 1, "R7");
        // R9: enable drop during high and low phases
        hold(10, 1, 0, 1, 1, 1, "R9");
        hold(3, 1, 0, 0, 1, 1, "R9");
        hold(10, 1, 0, 1, 1, 1, "R9");
        hold(12, 0, 1, 1, 1, 1, "R9");
        hold(2, 0, 1, 0, 1, 1, "R9");
        hold(10, 0, 1, 1, 1, 1, "R9");
        // R10 plus full model under random patterns
        for (int k = 0; k < 600; k++) begin
            int    sel = $urandom_range(0, 9);
            int    dur = $urandom_range(1, 9);
            logic  hi = (sel < 4);
            logic  lo = (sel >= 4 && sel < 8) || (sel == 9);
            if (sel == 9) hi = 1'b1;
            for (int j = 0; j < dur; j++)
                cyc(hi, lo, ($urandom_range(0, 19) != 0), ($urandom_range(0, 7) != 0),
                    ($urandom_range(0, 3) != 0), "R10");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule